// File: doc/BRIEF.md
# Independent Keyed Watchdog Timer

The block is a watchdog that runs on a slow clock of its own. One of two low-speed clock-enable strobes is chosen. The chosen strobe feeds a prescaler, and the prescaler feeds a 12-bit down-counter. Software arms the watchdog in one of two ways: it writes a start key through a plain write strobe, or a hardware option input arms it. While armed, software must keep writing a refresh key. If the counter runs out first, the block emits a one-cycle reset pulse. It then reloads to full scale and keeps counting, so a neglected system gets a reset again after every period.

A register write can never disarm the watchdog; only the block reset can. A debug input pair can freeze the count while the system is halted for debugging. A standby input forces the second clock-enable source, whatever the source select says.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `armed` is 0, `count` is 0xFFF and `wdt_rst_pulse` is 0.
- R2: The watchdog arms on the edge after `hw_arm` is high, or after a write whose `wr_data[3:0]` equals 4'b0101. Any other written value leaves it unarmed. Once armed, no write clears `armed`; only `rst_n` does.
- R3: While unarmed, `count` holds 0xFFF. While armed, `count` falls by one on every 2^(`div_sel`+2)-th edge on which the selected enable is high.
- R4: When the count is 0x000 and a prescaler tick arrives, `wdt_rst_pulse` is high for exactly one cycle. On that same edge `count` becomes 0xFFF, and counting goes on.
- R5: While armed, a write whose `wr_data[3:0]` equals 4'b1010 reloads `count` to 0xFFF and clears the prescaler. The upper 12 data bits are not compared. A write with any other low nibble leaves `count` unchanged.
- R6: If a refresh write and an expiry tick fall on the same edge, the refresh wins. No pulse is issued and `count` becomes 0xFFF.
- R7: While `dbg_halt` and `dbg_freeze_en` are both 1, the prescaler and the counter hold. With `dbg_freeze_en` at 0, counting goes on in debug mode.
- R8: `src_sel`=0 selects `tick_a` and `src_sel`=1 selects `tick_b`. `standby`=1 forces `tick_b`.
- R9: A change of `div_sel` clears the prescaler count on the edge where the new value is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_arm | input | 1 | Hardware option that arms the watchdog |
| wr_en | input | 1 | Key register write strobe |
| wr_data | input | 16 | Key register write data |
| src_sel | input | 1 | Clock-enable source select in run/stop modes |
| standby | input | 1 | Standby mode, forces source B |
| tick_a | input | 1 | Low-speed clock enable, source A |
| tick_b | input | 1 | Low-speed clock enable, source B |
| dbg_halt | input | 1 | System is halted in debug mode |
| dbg_freeze_en | input | 1 | Freeze the counter while in debug mode |
| div_sel | input | 3 | Prescaler select N, divide by 2^(N+2) |
| wdt_rst_pulse | output | 1 | One-cycle reset request on timeout |
| count | output | 12 | Current down-counter value |
| armed | output | 1 | Watchdog is running |

## Verification
The refresh write and the expiry tick can land on the same edge. This is the race that decides whether a late refresh still saves the system. The bench provokes it by refreshing at a known instant and counting 16383 edges at divide-by-4. It then issues the second refresh exactly on the edge where the counter at 0x000 receives its tick. It judges the outcome by a missing pulse together with a count of 0xFFF. Random traffic with refresh-key writes mixed in gives further chances of the same collision, and a bench model that gives refresh priority checks each one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned KEY_W       = 4;
   localparam logic [3:0]  REFRESH_KEY = 4'b1010;
   localparam logic [3:0]  ARM_KEY     = 4'b0101;

   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } tick_src_e;

   typedef struct packed {
      logic refresh;
      logic arm;
   } key_hit_t;
endpackage

// File: rtl/wdt_clk_sel.sv
module wdt_clk_sel #(
   parameter bit SYNC_TICKS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic standby,
   input  logic tick_a,
   input  logic tick_b,
   input  logic dbg_halt,
   input  logic dbg_freeze_en,
   output logic cnt_en
);
   import wdt_pkg::*;

   tick_src_e src;
   logic      raw_en;
   logic      frozen;

   always_comb begin
      src    = (standby || src_sel) ? SRC_B : SRC_A;
      raw_en = (src == SRC_B) ? tick_b : tick_a;
      frozen = dbg_halt && dbg_freeze_en;
   end

   generate
      if (SYNC_TICKS) begin : g_sync
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= raw_en && !frozen;
         end
         assign cnt_en = en_q;
      end else begin : g_direct
         assign cnt_en = raw_en && !frozen;
      end
   endgenerate

   a_r8_standby_forces_b: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !tick_b) |-> (src == SRC_B && !raw_en));
endmodule

// File: rtl/wdt_key_decode.sv
module wdt_key_decode #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output wdt_pkg::key_hit_t hit
);
   import wdt_pkg::*;

   generate
      if (DATA_W < KEY_W) begin : g_bad_width
         $error("wdt_key_decode: DATA_W narrower than key field");
      end
   endgenerate

   logic [KEY_W-1:0] key_field;

   always_comb begin
      key_field   = wr_data[KEY_W-1:0];
      hit.refresh = wr_en && (key_field == REFRESH_KEY);
      hit.arm     = wr_en && (key_field == ARM_KEY);
   end

   always_comb begin
      a_r5_keys_exclusive: assert (!(hit.refresh && hit.arm));
   end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned BASE_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             clear,
   input  logic             cnt_en,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);
   localparam int unsigned PSC_W = BASE_SHIFT + (1 << SEL_W) - 1;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("wdt_prescaler: SEL_W out of range");
      end
      if (PSC_W < 1) begin : g_bad_psc
         $error("wdt_prescaler: prescaler width below one");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   logic [PSC_W-1:0] psc_cnt;
   logic [PSC_W:0]   span;
   logic [PSC_W:0]   limit;
   logic             sel_changed;
   logic             at_limit;

   always_comb begin
      span        = (PSC_W+1)'(1) << (32'(sel_q) + BASE_SHIFT);
      limit       = span - (PSC_W+1)'(1);
      sel_changed = (div_sel != sel_q);
      at_limit    = (psc_cnt == limit[PSC_W-1:0]);
      tick        = active && !clear && !sel_changed && cnt_en && at_limit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         psc_cnt <= '0;
      end else begin
         sel_q <= div_sel;
         if (!active || clear || sel_changed) psc_cnt <= '0;
         else if (cnt_en) psc_cnt <= at_limit ? '0 : psc_cnt + 1'b1;
      end
   end

   a_r9_sel_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel != sel_q) |=> (psc_cnt == '0));
   a_r3_psc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, psc_cnt} <= limit));
   a_r5_clear_resets_psc: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (psc_cnt == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_req,
   input  logic             refresh,
   input  logic             tick,
   output logic             armed,
   output logic [CNT_W-1:0] count,
   output logic             expire_pulse
);
   localparam logic [CNT_W-1:0] FULL = '1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("wdt_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed        <= 1'b0;
         count        <= FULL;
         expire_pulse <= 1'b0;
      end else begin
         expire_pulse <= 1'b0;
         if (!armed) begin
            armed <= arm_req;
            count <= FULL;
         end else if (refresh) begin
            count <= FULL;
         end else if (tick) begin
            if (count == '0) begin
               count        <= FULL;
               expire_pulse <= 1'b1;
            end else begin
               count <= count - 1'b1;
            end
         end
      end
   end

   a_r2_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
   a_r3_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (count == FULL));
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      expire_pulse |=> !expire_pulse);
   a_r4_pulse_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      expire_pulse |-> (count == FULL));
   a_r6_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && refresh) |=> (count == FULL && !expire_pulse));
   a_r3_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !refresh && !tick) |=> $stable(count));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned BASE_SHIFT = 2,
   parameter bit          SYNC_TICKS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_arm,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              src_sel,
   input  logic              standby,
   input  logic              tick_a,
   input  logic              tick_b,
   input  logic              dbg_halt,
   input  logic              dbg_freeze_en,
   input  logic [SEL_W-1:0]  div_sel,
   output logic              wdt_rst_pulse,
   output logic [CNT_W-1:0]  count,
   output logic              armed
);
   import wdt_pkg::*;

   key_hit_t hit;
   logic     cnt_en;
   logic     psc_tick;
   logic     arm_req;
   logic     refresh_live;

   wdt_key_decode #(.DATA_W(DATA_W)) u_keys (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .hit     (hit)
   );

   wdt_clk_sel #(.SYNC_TICKS(SYNC_TICKS)) u_clk_sel (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_sel       (src_sel),
      .standby       (standby),
      .tick_a        (tick_a),
      .tick_b        (tick_b),
      .dbg_halt      (dbg_halt),
      .dbg_freeze_en (dbg_freeze_en),
      .cnt_en        (cnt_en)
   );

   assign arm_req      = hw_arm || hit.arm;
   assign refresh_live = armed && hit.refresh;

   wdt_prescaler #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (armed),
      .clear   (refresh_live),
      .cnt_en  (cnt_en),
      .div_sel (div_sel),
      .tick    (psc_tick)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_req      (arm_req),
      .refresh      (refresh_live),
      .tick         (psc_tick),
      .armed        (armed),
      .count        (count),
      .expire_pulse (wdt_rst_pulse)
   );

   generate
      if (!SYNC_TICKS) begin : g_freeze_chk
         a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (dbg_halt && dbg_freeze_en && !hit.refresh) |=> $stable(count));
      end
   endgenerate

   a_r2_arm_key: assert property (@(posedge clk) disable iff (!rst_n)
      (hit.arm || hw_arm) |=> armed);
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_arm = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        src_sel = 1'b0;
   logic        standby = 1'b0;
   logic        tick_a = 1'b0;
   logic        tick_b = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        dbg_freeze_en = 1'b0;
   logic [2:0]  div_sel = '0;
   logic        wdt_rst_pulse;
   logic [11:0] count;
   logic        armed;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   int unsigned cycles = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   keyed_wdt u_keyed_wdt (
      .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm), .wr_en(wr_en), .wr_data(wr_data),
      .src_sel(src_sel), .standby(standby), .tick_a(tick_a), .tick_b(tick_b),
      .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze_en), .div_sel(div_sel),
      .wdt_rst_pulse(wdt_rst_pulse), .count(count), .armed(armed)
   );

   // Reference model built from the requirements
   logic        m_run, m_pulse;
   logic [11:0] m_cnt;
   logic [9:0]  m_psc;
   logic [2:0]  m_sel;

   function automatic logic sel_en(logic ss, logic sb, logic ta, logic tb);
      return (sb || ss) ? tb : ta;
   endfunction

   function automatic logic [9:0] psc_top(logic [2:0] n);
      return 10'((4 << n) - 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run <= 1'b0; m_pulse <= 1'b0; m_cnt <= 12'hFFF; m_psc <= '0; m_sel <= '0;
      end else begin
         m_pulse <= 1'b0;
         m_sel   <= div_sel;
         if (!m_run) begin
            m_run <= hw_arm || (wr_en && wr_data[3:0] == 4'b0101);
            m_cnt <= 12'hFFF;
            m_psc <= '0;
         end else if (wr_en && wr_data[3:0] == 4'b1010) begin
            m_cnt <= 12'hFFF;
            m_psc <= '0;
         end else if (div_sel != m_sel) begin
            m_psc <= '0;
         end else if (sel_en(src_sel, standby, tick_a, tick_b) && !(dbg_halt && dbg_freeze_en)) begin
            if (m_psc == psc_top(m_sel)) begin
               m_psc <= '0;
               if (m_cnt == 12'h000) begin
                  m_cnt <= 12'hFFF; m_pulse <= 1'b1;
               end else begin
                  m_cnt <= m_cnt - 12'd1;
               end
            end else begin
               m_psc <= m_psc + 10'd1;
            end
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 model count", 32'(count), 32'(m_cnt));
         chk("R4 model pulse", 32'(wdt_rst_pulse), 32'(m_pulse));
         chk("R2 model armed", 32'(armed), 32'(m_run));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic wr(logic [15:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      int unsigned seed_init;
      int unsigned pulses;
      seed_init = $urandom(32'h5EED_2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 armed", 32'(armed), 0);
      chk("R1 count", 32'(count), 32'hFFF);
      chk("R1 pulse", 32'(wdt_rst_pulse), 0);

      wr(16'hABC3);
      chk("R2 wrong key ignored", 32'(armed), 0);
      wr(16'h000A);
      chk("R5 refresh while idle", 32'(armed), 0);
      wr(16'hF0F5);
      chk("R2 arm key", 32'(armed), 1);

      src_sel = 1'b1; tick_a = 1'b1; tick_b = 1'b0;
      repeat (20) @(negedge clk);
      chk("R8 source B selected", 32'(count), 32'hFFF);
      src_sel = 1'b0; standby = 1'b1;
      repeat (20) @(negedge clk);
      chk("R8 standby forces B", 32'(count), 32'hFFF);
      standby = 1'b0;
      repeat (40) @(negedge clk);
      chk("R3 divide by 4", 32'(count), 32'hFF5);

      dbg_halt = 1'b1; dbg_freeze_en = 1'b1;
      repeat (20) @(negedge clk);
      chk("R7 frozen", 32'(count), 32'hFF5);
      dbg_freeze_en = 1'b0;
      repeat (8) @(negedge clk);
      chk("R7 debug without freeze", 32'(count), 32'hFF3);
      dbg_halt = 1'b0;

      tick_a = 1'b0;
      wr(16'hA5A0);
      chk("R5 wrong nibble ignored", 32'(count), 32'hFF3);
      wr(16'h123A);
      chk("R5 refresh reload", 32'(count), 32'hFFF);
      wr(16'h0000);
      wr(16'hFFFF);
      chk("R2 writes cannot disarm", 32'(armed), 1);

      tick_a = 1'b1;
      repeat (3) @(negedge clk);
      tick_a = 1'b0; div_sel = 3'd1;
      @(negedge clk);
      tick_a = 1'b1;
      repeat (7) @(negedge clk);
      chk("R9 prescaler cleared", 32'(count), 32'hFFF);
      @(negedge clk);
      chk("R9 first tick at 8", 32'(count), 32'hFFE);

      tick_a = 1'b0; div_sel = 3'd0;
      @(negedge clk);
      tick_a = 1'b1;
      wr(16'h000A);
      repeat (16383) @(negedge clk);
      chk("R4 count at zero", 32'(count), 32'h000);
      wr(16'h777A);
      chk("R6 no pulse on collision", 32'(wdt_rst_pulse), 0);
      chk("R6 count reloaded", 32'(count), 32'hFFF);
      pulses = 0;
      for (int i = 0; i < 16390; i++) begin
         @(negedge clk);
         if (wdt_rst_pulse) begin
            pulses++;
            chk("R4 reload at pulse", 32'(count), 32'hFFF);
         end
      end
      chk("R4 one pulse cycle", pulses, 1);
      chk("R4 keeps running", 32'(armed), 1);

      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset disarms", 32'(armed), 0);
      hw_arm = 1'b1;
      @(negedge clk);
      hw_arm = 1'b0;
      chk("R2 hardware arm", 32'(armed), 1);

      for (int i = 0; i < 6000; i++) begin
         tick_a = ($urandom % 3) != 0;
         tick_b = ($urandom % 2) != 0;
         if ($urandom % 50 == 0) src_sel = ~src_sel;
         if ($urandom % 80 == 0) standby = ~standby;
         if ($urandom % 60 == 0) dbg_halt = ~dbg_halt;
         if ($urandom % 60 == 0) dbg_freeze_en = ~dbg_freeze_en;
         if ($urandom % 500 == 0) div_sel = 3'($urandom % 3);
         if ($urandom % 40 == 0) begin
            wr_en = 1'b1;
            wr_data = 16'($urandom);
            if ($urandom % 2 == 0) wr_data[3:0] = 4'b1010;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule